// File: doc/BRIEF.md
# Speculation Shadow Matrix

This block tracks which speculative conditions each function unit is waiting on before it may write a result. A shadow source is a speculative branch, an instruction that might still trap, or a pending predicate mask. Each source owns one column of a bit matrix, and each function unit owns one row. When a unit issues, it records in its row every column that is open at that moment. The unit cannot enter its writeable state until every recorded column has reported success.

A failure on any recorded column kills the unit. The kill output fires in the same cycle as the failure. The unit's busy state drops on the next edge, and a registered cancel is passed on to the compute unit behind it.

Branch and exception columns resolve with an explicit ok or fail strobe. A predicate column resolves with a mask. The mask is decoded per element, and each element maps to one function unit: a zero bit kills that unit and a one bit releases it. A resolved column is cleared in every row, so a new source can reuse it at once.

Top module: `shadow_matrix`

## Requirements
- R1: Out of reset, shadow_active, fu_busy, fu_writeable, fu_go_die and cu_cancel are all zero.
- R2: Columns are ordered with branch sources at the lowest indices, then exception sources, then predicate sources. A pulse on src_open[c] sets shadow_active[c] on the next edge. Resolving column c clears it on the next edge. A branch or exception column resolves through gen_ok[c] or gen_fail[c]. Predicate column NUM_BR+NUM_EXC+p resolves through pred_valid[p].
- R3: An issue_valid strobe naming an idle unit sets that unit's fu_busy on the next edge. The unit records every open column, except a column that resolves in that same cycle. An issue naming a unit that is already busy is ignored and leaves its recorded shadows unchanged.
- R4: fu_writeable[i] is high exactly when unit i is busy and has no recorded shadow left. A success clears its bit at the next edge, so writeable rises one cycle after the last outstanding success.
- R5: fu_go_die[i] is high in the same cycle that any column recorded by busy unit i fails. If ok and fail arrive together on a column, the fail takes precedence.
- R6: A unit that receives go-die has fu_busy and fu_writeable low from the next edge onward.
- R7: cu_cancel[i] is high in exactly the one cycle that follows a cycle with fu_go_die[i] high.
- R8: For predicate p, bit p*NUM_FU+i of pred_mask belongs to unit i. With pred_valid[p] high, a 0 in that bit kills unit i if unit i recorded that column. A 1 in that bit releases unit i from that column.
- R9: A fu_done[i] pulse clears fu_busy[i] on the next edge.
- R10: Resolving a column that a unit did not record, whether by fail or by a zero mask bit, neither kills that unit nor changes its writeable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_open | input | NUM_SRC | Open a shadow column (one pulse per new source) |
| gen_ok | input | NUM_BR+NUM_EXC | Success strobe for branch and exception columns |
| gen_fail | input | NUM_BR+NUM_EXC | Failure strobe for branch and exception columns |
| pred_valid | input | NUM_PRED | Predicate mask for this column is valid this cycle |
| pred_mask | input | NUM_PRED*NUM_FU | Per-unit mask bits, NUM_FU bits per predicate column |
| issue_valid | input | 1 | A unit is issuing this cycle |
| issue_fu | input | $clog2(NUM_FU) | Index of the issuing unit |
| fu_done | input | NUM_FU | Unit has finished and releases its row |
| shadow_active | output | NUM_SRC | Columns currently open |
| fu_busy | output | NUM_FU | Row holds an issued unit |
| fu_writeable | output | NUM_FU | Unit is free of all shadows |
| fu_go_die | output | NUM_FU | Kill strobe to the unit, same cycle as the failure |
| cu_cancel | output | NUM_FU | Registered cancel to the compute unit |

## Verification
fu_go_die is combinational from registered rows and the current strobes, so the bench samples it one time step after driving, in the cycle the fail or mask is applied. fu_busy, fu_writeable, shadow_active and the cleared row bits pass through one register, so the bench samples them at the following negative edge. cu_cancel is checked at that same point and again one cycle later, to show it lasts exactly one cycle. Every input is driven just after a falling edge, which keeps each sample clear of the edge that updates the state.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    typedef enum logic [1:0] {
        COL_BRANCH = 2'd0,
        COL_EXCEPT = 2'd1,
        COL_PRED   = 2'd2
    } col_kind_e;

    // Column ordering: branches first, then exception sources, then predicates.
    function automatic col_kind_e kind_of(input int col, input int n_br, input int n_exc);
        if (col < n_br)
            return COL_BRANCH;
        else if (col < n_br + n_exc)
            return COL_EXCEPT;
        else
            return COL_PRED;
    endfunction

endpackage

// File: rtl/shadow_pred_decode.sv
module shadow_pred_decode #(
    parameter int NUM_FU = 8
) (
    input  logic              valid,
    input  logic [NUM_FU-1:0] mask,
    output logic [NUM_FU-1:0] elem_fail,
    output logic [NUM_FU-1:0] elem_pass
);

    // Each mask bit is one element; zero cancels, one releases.
    always_comb begin
        elem_fail = '0;
        elem_pass = '0;
        if (valid) begin
            elem_fail = ~mask;
            elem_pass = mask;
        end
    end

endmodule

// File: rtl/shadow_resolve.sv
module shadow_resolve
    import shadow_pkg::*;
#(
    parameter int NUM_FU   = 8,
    parameter int NUM_BR   = 2,
    parameter int NUM_EXC  = 2,
    parameter int NUM_PRED = 2,
    localparam int NUM_GEN = NUM_BR + NUM_EXC,
    localparam int NUM_SRC = NUM_GEN + NUM_PRED
) (
    input  logic [NUM_GEN-1:0]              gen_ok,
    input  logic [NUM_GEN-1:0]              gen_fail,
    input  logic [NUM_PRED-1:0]             pred_valid,
    input  logic [NUM_PRED*NUM_FU-1:0]      pred_mask,
    output logic [NUM_SRC-1:0]              col_done,
    output logic [NUM_FU-1:0][NUM_SRC-1:0]  kill,
    output logic [NUM_FU-1:0][NUM_SRC-1:0]  clr
);

    for (genvar c = 0; c < NUM_SRC; c++) begin : g_col
        if (kind_of(c, NUM_BR, NUM_EXC) == COL_PRED) begin : g_pred
            localparam int P = c - NUM_GEN;
            logic [NUM_FU-1:0] el_fail;
            logic [NUM_FU-1:0] el_pass;

            shadow_pred_decode #(.NUM_FU(NUM_FU)) i_dec (
                .valid     (pred_valid[P]),
                .mask      (pred_mask[P*NUM_FU +: NUM_FU]),
                .elem_fail (el_fail),
                .elem_pass (el_pass)
            );

            for (genvar i = 0; i < NUM_FU; i++) begin : g_row
                assign kill[i][c] = el_fail[i];
                assign clr[i][c]  = el_fail[i] | el_pass[i];
            end
            assign col_done[c] = pred_valid[P];
        end else begin : g_gen
            // Fail has precedence: kill is raised whenever fail is present.
            for (genvar i = 0; i < NUM_FU; i++) begin : g_row
                assign kill[i][c] = gen_fail[c];
                assign clr[i][c]  = gen_ok[c] | gen_fail[c];
            end
            assign col_done[c] = gen_ok[c] | gen_fail[c];
        end
    end

endmodule

// File: rtl/shadow_matrix.sv
module shadow_matrix #(
    parameter int NUM_FU   = 8,
    parameter int NUM_BR   = 2,
    parameter int NUM_EXC  = 2,
    parameter int NUM_PRED = 2,
    localparam int NUM_GEN = NUM_BR + NUM_EXC,
    localparam int NUM_SRC = NUM_GEN + NUM_PRED,
    localparam int FU_W    = $clog2(NUM_FU)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_open,
    input  logic [NUM_GEN-1:0]         gen_ok,
    input  logic [NUM_GEN-1:0]         gen_fail,
    input  logic [NUM_PRED-1:0]        pred_valid,
    input  logic [NUM_PRED*NUM_FU-1:0] pred_mask,
    input  logic                       issue_valid,
    input  logic [FU_W-1:0]            issue_fu,
    input  logic [NUM_FU-1:0]          fu_done,
    output logic [NUM_SRC-1:0]         shadow_active,
    output logic [NUM_FU-1:0]          fu_busy,
    output logic [NUM_FU-1:0]          fu_writeable,
    output logic [NUM_FU-1:0]          fu_go_die,
    output logic [NUM_FU-1:0]          cu_cancel
);

    typedef struct packed {
        logic [NUM_SRC-1:0]             active;
        logic [NUM_FU-1:0]              busy;
        logic [NUM_FU-1:0]              cancel;
        logic [NUM_FU-1:0][NUM_SRC-1:0] rows;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SRC-1:0]             col_done;
    logic [NUM_FU-1:0][NUM_SRC-1:0] kill;
    logic [NUM_FU-1:0][NUM_SRC-1:0] clr;
    logic [NUM_FU-1:0]              die;

    shadow_resolve #(
        .NUM_FU   (NUM_FU),
        .NUM_BR   (NUM_BR),
        .NUM_EXC  (NUM_EXC),
        .NUM_PRED (NUM_PRED)
    ) i_resolve (
        .gen_ok     (gen_ok),
        .gen_fail   (gen_fail),
        .pred_valid (pred_valid),
        .pred_mask  (pred_mask),
        .col_done   (col_done),
        .kill       (kill),
        .clr        (clr)
    );

    always_comb begin
        st_d = st_q;
        // Columns resolving now are freed; an open in the same cycle re-arms.
        st_d.active = (st_q.active & ~col_done) | src_open;
        for (int i = 0; i < NUM_FU; i++) begin
            die[i]        = st_q.busy[i] & (|(st_q.rows[i] & kill[i]));
            st_d.rows[i]  = st_q.rows[i] & ~clr[i];
            if (die[i] || fu_done[i]) begin
                st_d.busy[i] = 1'b0;
                st_d.rows[i] = '0;
            end
            if (issue_valid && (issue_fu == FU_W'(i)) && !st_q.busy[i]) begin
                st_d.busy[i] = 1'b1;
                st_d.rows[i] = st_q.active & ~col_done;
            end
        end
        st_d.cancel = die;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_FU; i++)
            fu_writeable[i] = st_q.busy[i] && (st_q.rows[i] == '0);
    end

    assign shadow_active = st_q.active;
    assign fu_busy       = st_q.busy;
    assign fu_go_die     = die;
    assign cu_cancel     = st_q.cancel;

endmodule

// File: rtl/shadow_matrix_chk.sv
module shadow_matrix_chk #(
    parameter int NUM_FU   = 8,
    parameter int NUM_BR   = 2,
    parameter int NUM_EXC  = 2,
    parameter int NUM_PRED = 2,
    localparam int NUM_GEN = NUM_BR + NUM_EXC,
    localparam int NUM_SRC = NUM_GEN + NUM_PRED
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  src_open,
    input logic [NUM_GEN-1:0]  gen_ok,
    input logic [NUM_GEN-1:0]  gen_fail,
    input logic [NUM_PRED-1:0] pred_valid,
    input logic [NUM_SRC-1:0]  shadow_active,
    input logic [NUM_FU-1:0]   fu_busy,
    input logic [NUM_FU-1:0]   fu_writeable,
    input logic [NUM_FU-1:0]   fu_go_die,
    input logic [NUM_FU-1:0]   cu_cancel
);

    logic [NUM_SRC-1:0] resolving;
    assign resolving = {pred_valid, gen_ok | gen_fail} & ~src_open;

    assert_open_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_open) |=> ((shadow_active & $past(src_open)) == $past(src_open)));

    assert_resolve_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|resolving) |=> ((shadow_active & $past(resolving)) == '0));

    assert_writeable_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_writeable & (~fu_busy | fu_go_die)) == '0);

    assert_die_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fu_go_die & ~fu_busy) == '0);

    assert_die_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|fu_go_die) |=> ((fu_busy & $past(fu_go_die)) == '0));

    assert_cancel_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cu_cancel == $past(fu_go_die)));

endmodule

bind shadow_matrix shadow_matrix_chk #(
    .NUM_FU   (NUM_FU),
    .NUM_BR   (NUM_BR),
    .NUM_EXC  (NUM_EXC),
    .NUM_PRED (NUM_PRED)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_open      (src_open),
    .gen_ok        (gen_ok),
    .gen_fail      (gen_fail),
    .pred_valid    (pred_valid),
    .shadow_active (shadow_active),
    .fu_busy       (fu_busy),
    .fu_writeable  (fu_writeable),
    .fu_go_die     (fu_go_die),
    .cu_cancel     (cu_cancel)
);

// File: tb/test_shadow_matrix.sv
module test_shadow_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int NFU = 4;
    localparam int NSRC = 3;   // col0 branch, col1 exception, col2 predicate

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src_open = '0;
    logic [1:0]      gen_ok = '0;
    logic [1:0]      gen_fail = '0;
    logic [0:0]      pred_valid = '0;
    logic [NFU-1:0]  pred_mask = '0;
    logic            issue_valid = 1'b0;
    logic [1:0]      issue_fu = '0;
    logic [NFU-1:0]  fu_done = '0;
    logic [NSRC-1:0] shadow_active;
    logic [NFU-1:0]  fu_busy, fu_writeable, fu_go_die, cu_cancel;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shadow_matrix #(.NUM_FU(NFU), .NUM_BR(1), .NUM_EXC(1), .NUM_PRED(1)) i_shadow_matrix (
        .clk(clk), .rst_n(rst_n), .src_open(src_open), .gen_ok(gen_ok),
        .gen_fail(gen_fail), .pred_valid(pred_valid), .pred_mask(pred_mask),
        .issue_valid(issue_valid), .issue_fu(issue_fu), .fu_done(fu_done),
        .shadow_active(shadow_active), .fu_busy(fu_busy),
        .fu_writeable(fu_writeable), .fu_go_die(fu_go_die), .cu_cancel(cu_cancel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        src_open = '0; gen_ok = '0; gen_fail = '0; pred_valid = '0;
        pred_mask = '0; issue_valid = 1'b0; fu_done = '0;
    endtask

    task automatic flush();
        fu_done = '1; tick(); fu_done = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 active", 32'(shadow_active), 0);
        chk("R1 busy", 32'(fu_busy), 0);
        chk("R1 writeable", 32'(fu_writeable), 0);
        chk("R1 go_die", 32'(fu_go_die), 0);
        chk("R1 cancel", 32'(cu_cancel), 0);

        // Sweep: every set of open columns against every fail/success pattern
        for (int act = 0; act < 8; act++) begin
            for (int o = 0; o < 8; o++) begin
                logic die;
                die = |(act[2:0] & o[2:0]);
                src_open = act[2:0]; tick(); idle();
                chk("R2 opened", 32'(shadow_active), 32'(act));
                issue_valid = 1'b1; issue_fu = 2'd0; tick(); idle();
                chk("R3 busy after issue", 32'(fu_busy[0]), 1);
                chk("R4 writeable before resolve", 32'(fu_writeable[0]), 32'(act == 0));
                gen_ok = ~o[1:0]; gen_fail = o[1:0];
                pred_valid = 1'b1; pred_mask = o[2] ? 4'b1110 : 4'b1111;
                #1;
                chk(act[2] ? "R8 go_die" : "R5 R10 go_die", 32'(fu_go_die[0]), 32'(die));
                tick(); idle();
                chk("R6 busy after resolve", 32'(fu_busy[0]), 32'(!die));
                chk("R4 writeable after resolve", 32'(fu_writeable[0]), 32'(!die));
                chk("R7 cancel", 32'(cu_cancel[0]), 32'(die));
                chk("R2 all cleared", 32'(shadow_active), 0);
                fu_done[0] = 1'b1; tick(); idle();
                chk("R7 cancel one cycle", 32'(cu_cancel[0]), 0);
                chk("R9 done clears busy", 32'(fu_busy[0]), 0);
            end
        end

        // R8: predicate mask across all four units
        src_open = 3'b100; tick(); idle();
        for (int i = 0; i < NFU; i++) begin
            issue_valid = 1'b1; issue_fu = 2'(i); tick(); idle();
        end
        chk("R8 all busy", 32'(fu_busy), 32'hF);
        pred_valid = 1'b1; pred_mask = 4'b1010; #1;
        chk("R8 zero bits die", 32'(fu_go_die), 32'h5);
        tick(); idle();
        chk("R8 survivors busy", 32'(fu_busy), 32'hA);
        chk("R8 survivors writeable", 32'(fu_writeable), 32'hA);
        chk("R7 cancel vector", 32'(cu_cancel), 32'h5);
        flush();

        // R5: fail wins over ok on the same column
        src_open = 3'b001; tick(); idle();
        issue_valid = 1'b1; issue_fu = 2'd1; tick(); idle();
        gen_ok = 2'b01; gen_fail = 2'b01; #1;
        chk("R5 fail wins", 32'(fu_go_die), 32'h2);
        tick(); idle();
        chk("R6 killed unit idle", 32'(fu_busy), 0);

        // R3: issue to a busy unit is ignored; R10 unrecorded fail
        src_open = 3'b001; tick(); idle();
        issue_valid = 1'b1; issue_fu = 2'd2; tick(); idle();
        src_open = 3'b010; tick(); idle();
        issue_valid = 1'b1; issue_fu = 2'd2; tick(); idle();
        gen_ok = 2'b01; tick(); idle();
        chk("R3 reissue ignored", 32'(fu_writeable), 32'h4);
        gen_fail = 2'b10; #1;
        chk("R10 unrecorded fail", 32'(fu_go_die), 0);
        tick(); idle();
        chk("R10 still writeable", 32'(fu_writeable), 32'h4);
        flush();

        // R3: column resolving in the issue cycle is not recorded
        src_open = 3'b001; tick(); idle();
        issue_valid = 1'b1; issue_fu = 2'd3; gen_ok = 2'b01; tick(); idle();
        chk("R3 same-cycle resolve", 32'(fu_writeable), 32'h8);
        flush();

        // R4: writeable only after the last of two successes
        src_open = 3'b011; tick(); idle();
        issue_valid = 1'b1; issue_fu = 2'd0; tick(); idle();
        gen_ok = 2'b01; tick(); idle();
        chk("R4 one success left", 32'(fu_writeable), 0);
        gen_ok = 2'b10; tick(); idle();
        chk("R4 all successes", 32'(fu_writeable), 32'h1);
        flush();
        chk("R9 flush idle", 32'(fu_busy), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule